// File: doc/BRIEF.md
# Region-Based Data Access Checker

This block sits between a processor core's data port and the downstream bus. It inspects every load and store. The core presents an address, a privilege bit, a direction bit, a speculation flag and a relocation-enable level. The block replies exactly one clock later with one of three one-cycle answers:

- **accept**: forward the access, together with the guarded attribute of the region that decided it;
- **retry**: the core must reissue the bus cycle;
- **exception**: raise a data storage exception.

Four programmable regions are checked in parallel. Each region has a base, a compare mask (the ones in the mask mark the address bits that must equal the base) and an attribute word holding an enable bit, a 2-bit protection code and a guarded bit. If several enabled regions contain the address, the lowest-numbered one is the effective region. If none does, a separate global attribute word applies. A speculative access to guarded memory is held off with retries rather than faulted, so any violation surfaces only once the core reissues the access non-speculatively. When relocation is off, the core's accesses are never faulted and all memory counts as guarded. Two fixed address windows (calibration RAM and the local bus) and accesses flagged as core-register accesses skip the check altogether.

Software programs the regions through a single-cycle address/data/write-enable port. The read data of that port is combinational.

Top module: `dpu_top`

## Requirements
- R1: A request presented with `reqValid` high gets exactly one of `rspAccept`, `rspRetry`, `rspExcept` high during the single cycle after it. With no request in a cycle, all three are low in the following cycle.
- R2: An enabled region contains an address when `(addr ^ base) & mask` is zero. When several enabled regions contain the address, the one with the lowest index decides. Disabled regions are never considered.
- R3: When no enabled region contains the address, the global attribute word decides.
- R4: Protection codes: 00 grants nothing; 01 grants supervisor read and write only; 10 grants supervisor read and write plus user read; 11 grants everything. `reqSuper`=1 marks supervisor mode and `reqWrite`=1 marks a store.
- R5: With `relocEn`=1, an access that its effective code does not grant, and that is not held off by R6, gets `rspExcept`.
- R6: With `relocEn`=1, a speculative access whose effective region is guarded gets `rspRetry`, whether or not the code grants it. A granted access that is not held off gets `rspAccept`, and `rspGuarded` equals the effective region's guarded bit.
- R7: With `relocEn`=0, no exception is ever raised. A speculative access gets `rspRetry`. A non-speculative access gets `rspAccept` with `rspGuarded`=1.
- R8: Accesses inside the calibration window (default 0x0030_0000 to 0x003F_FFFF), inside the local-bus window (default 0x0080_0000 to 0x00FF_FFFF), or with `reqCoreReg`=1 get `rspAccept` with `rspGuarded`=0, whatever the regions, relocation or speculation say.
- R9: Configuration map (`cfgAddr` = {kind[1:0], index[1:0]}): kind 0 is region base, kind 1 is region mask, kind 2 is region attribute, and kind 3 with index 0 is the global attribute. Other kind-3 addresses read 0 and ignore writes. The attribute layout is bit0 enable, bits[2:1] protection, bit3 guarded; the global word always reads its enable bit as 0. After reset every base, mask and region attribute is 0, and the global attribute reads 0x6 (full access, not guarded).
- R10: A request presented with `reqCancel` high gets no response at all in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration register select {kind, index} |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Configuration read data for `cfgAddr` (combinational) |
| reqValid | input | 1 | Data access request present |
| reqAddr | input | 32 | Access address |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqSuper | input | 1 | 1 = supervisor mode |
| reqSpec | input | 1 | 1 = access is speculative |
| reqCoreReg | input | 1 | 1 = access targets core registers; skips the check |
| reqCancel | input | 1 | Core withdraws the request in this cycle |
| relocEn | input | 1 | Data relocation enable from the core |
| rspAccept | output | 1 | Access may proceed downstream |
| rspRetry | output | 1 | Core must retry the bus cycle |
| rspExcept | output | 1 | Data storage exception |
| rspGuarded | output | 1 | Guarded attribute accompanying an accept |

## Verification
A corrupted region register or a broken priority chain shows up one cycle after the first access that reaches that region. It appears as the wrong choice among accept, retry and exception, or as a wrong guarded flag, and the register read port exposes the stored value at once. Faults in the speculation and relocation paths flip a retry into an exception or an accept on the very next response. For this reason the random accesses are aimed inside programmed regions, at their overlaps and at the exclusion windows, and each response is compared against a model built from the register map.

// File: rtl/dpu_pkg.sv
package dpu_pkg;

  localparam logic [1:0] PROT_NONE      = 2'b00;
  localparam logic [1:0] PROT_SUPER     = 2'b01;
  localparam logic [1:0] PROT_USER_READ = 2'b10;
  localparam logic [1:0] PROT_FULL      = 2'b11;

  typedef struct packed {
    logic       en;
    logic       guard;
    logic [1:0] prot;
  } regionAttr_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrBase;
    logic wrMask;
    logic wrAttr;
    logic wrGlobal;
  } cfgStrobe_t;

  // lookup result from datapath to control
  typedef struct packed {
    logic       bypass;
    logic       guard;
    logic [1:0] prot;
  } lookup_t;

  typedef struct packed {
    logic accept;
    logic retry;
    logic except;
    logic guarded;
  } resp_t;

  function automatic logic protGrants(input logic [1:0] prot, input logic isSuper,
                                      input logic isWrite);
    case (prot)
      PROT_NONE:      protGrants = 1'b0;
      PROT_SUPER:     protGrants = isSuper;
      PROT_USER_READ: protGrants = isSuper | ~isWrite;
      default:        protGrants = 1'b1;
    endcase
  endfunction

  function automatic regionAttr_t unpackAttr(input logic [3:0] d);
    regionAttr_t a;
    a.en    = d[0];
    a.prot  = d[2:1];
    a.guard = d[3];
    return a;
  endfunction

  function automatic logic [3:0] packAttr(input regionAttr_t a);
    return {a.guard, a.prot, a.en};
  endfunction

endpackage

// File: rtl/dpu_datapath.sv
module dpu_datapath
  import dpu_pkg::*;
#(
  parameter int NREG   = 4,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 2,
  parameter logic [ADDR_W-1:0] CAL_BASE  = 32'h0030_0000,
  parameter logic [ADDR_W-1:0] CAL_MASK  = 32'hFFF0_0000,
  parameter logic [ADDR_W-1:0] LBUS_BASE = 32'h0080_0000,
  parameter logic [ADDR_W-1:0] LBUS_MASK = 32'hFF80_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfgStrobe_t        strobe,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic [IDX_W+1:0]  cfgAddr,
  output logic [ADDR_W-1:0] cfgRdData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqCoreReg,
  output lookup_t           lk
);

  logic [ADDR_W-1:0] baseArr [NREG];
  logic [ADDR_W-1:0] maskArr [NREG];
  regionAttr_t       attrArr [NREG];
  logic [NREG-1:0]   matchVec;
  regionAttr_t       globQ;

  for (genvar g = 0; g < NREG; g++) begin : gRegion
    logic [ADDR_W-1:0] baseQ;
    logic [ADDR_W-1:0] maskQ;
    regionAttr_t       attrQ;
    logic              sel;

    assign sel = (wrIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        baseQ <= '0;
        maskQ <= '0;
        attrQ <= '0;
      end else begin
        if (strobe.wrBase && sel) baseQ <= cfgWrData;
        if (strobe.wrMask && sel) maskQ <= cfgWrData;
        if (strobe.wrAttr && sel) attrQ <= unpackAttr(cfgWrData[3:0]);
      end
    end

    assign baseArr[g]  = baseQ;
    assign maskArr[g]  = maskQ;
    assign attrArr[g]  = attrQ;
    assign matchVec[g] = attrQ.en && (((reqAddr ^ baseQ) & maskQ) == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      globQ.en    <= 1'b0;
      globQ.guard <= 1'b0;
      globQ.prot  <= PROT_FULL;
    end else if (strobe.wrGlobal) begin
      globQ.en    <= 1'b0;
      globQ.guard <= cfgWrData[3];
      globQ.prot  <= cfgWrData[2:1];
    end
  end

  // effective region: lowest matching index wins, global otherwise
  logic inCal, inLbus;
  assign inCal  = (((reqAddr ^ CAL_BASE) & CAL_MASK) == '0);
  assign inLbus = (((reqAddr ^ LBUS_BASE) & LBUS_MASK) == '0);

  always_comb begin
    lk.bypass = inCal | inLbus | reqCoreReg;
    lk.prot   = globQ.prot;
    lk.guard  = globQ.guard;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        lk.prot  = attrArr[i].prot;
        lk.guard = attrArr[i].guard;
      end
    end
  end

  // configuration read
  logic [1:0]       rdKind;
  logic [IDX_W-1:0] rdIdx;
  assign rdKind = cfgAddr[IDX_W+1:IDX_W];
  assign rdIdx  = cfgAddr[IDX_W-1:0];

  always_comb begin
    cfgRdData = '0;
    if (int'(rdIdx) < NREG) begin
      case (rdKind)
        2'd0:    cfgRdData = baseArr[rdIdx];
        2'd1:    cfgRdData = maskArr[rdIdx];
        2'd2:    cfgRdData = ADDR_W'(packAttr(attrArr[rdIdx]));
        default: cfgRdData = (rdIdx == '0) ? ADDR_W'(packAttr(globQ)) : '0;
      endcase
    end
  end

  // global word changes only on its own strobe
  p_glob_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.wrGlobal |=> $stable(globQ));

  // global word never carries an enable bit
  p_glob_noen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !globQ.en);

endmodule

// File: rtl/dpu_ctrl.sv
module dpu_ctrl
  import dpu_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWrEn,
  input  logic [IDX_W+1:0] cfgAddr,
  output cfgStrobe_t       strobe,
  output logic [IDX_W-1:0] wrIdx,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             reqSuper,
  input  logic             reqSpec,
  input  logic             reqCancel,
  input  logic             relocEn,
  input  lookup_t          lk,
  output logic             rspAccept,
  output logic             rspRetry,
  output logic             rspExcept,
  output logic             rspGuarded
);

  // configuration write decode
  assign wrIdx = cfgAddr[IDX_W-1:0];

  always_comb begin
    strobe = '0;
    if (cfgWrEn) begin
      case (cfgAddr[IDX_W+1:IDX_W])
        2'd0:    strobe.wrBase   = 1'b1;
        2'd1:    strobe.wrMask   = 1'b1;
        2'd2:    strobe.wrAttr   = 1'b1;
        default: strobe.wrGlobal = (wrIdx == '0);
      endcase
    end
  end

  // access decision
  resp_t nxt, rspQ;

  always_comb begin
    nxt = '0;
    if (reqValid && !reqCancel) begin
      if (lk.bypass) begin
        nxt.accept = 1'b1;
      end else if (!relocEn) begin
        if (reqSpec) begin
          nxt.retry = 1'b1;
        end else begin
          nxt.accept  = 1'b1;
          nxt.guarded = 1'b1;
        end
      end else if (lk.guard && reqSpec) begin
        nxt.retry = 1'b1;
      end else if (protGrants(lk.prot, reqSuper, reqWrite)) begin
        nxt.accept  = 1'b1;
        nxt.guarded = lk.guard;
      end else begin
        nxt.except = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rspQ <= '0;
    else        rspQ <= nxt;
  end

  assign rspAccept  = rspQ.accept;
  assign rspRetry   = rspQ.retry;
  assign rspExcept  = rspQ.except;
  assign rspGuarded = rspQ.guarded;

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rspAccept, rspRetry, rspExcept}));

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !(rspAccept || rspRetry || rspExcept));

  p_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqCancel) |=> !(rspAccept || rspRetry || rspExcept));

  p_spec_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqCancel && !lk.bypass && relocEn && lk.guard && reqSpec) |=> rspRetry);

  p_no_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !relocEn) |=> !rspExcept);

  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqCancel && lk.bypass) |=> (rspAccept && !rspGuarded));

  p_guard_only_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rspGuarded |-> rspAccept);

endmodule

// File: rtl/dpu_top.sv
module dpu_top
  import dpu_pkg::*;
#(
  parameter int NREG   = 4,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] CAL_BASE  = 32'h0030_0000,
  parameter logic [ADDR_W-1:0] CAL_MASK  = 32'hFFF0_0000,
  parameter logic [ADDR_W-1:0] LBUS_BASE = 32'h0080_0000,
  parameter logic [ADDR_W-1:0] LBUS_MASK = 32'hFF80_0000,
  localparam int IDX_W = $clog2(NREG),
  localparam int CFG_AW = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [ADDR_W-1:0] cfgWrData,
  output logic [ADDR_W-1:0] cfgRdData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqSuper,
  input  logic              reqSpec,
  input  logic              reqCoreReg,
  input  logic              reqCancel,
  input  logic              relocEn,
  output logic              rspAccept,
  output logic              rspRetry,
  output logic              rspExcept,
  output logic              rspGuarded
);

  cfgStrobe_t       strobe;
  logic [IDX_W-1:0] wrIdx;
  lookup_t          lk;

  dpu_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfgWrEn    (cfgWrEn),
    .cfgAddr    (cfgAddr),
    .strobe     (strobe),
    .wrIdx      (wrIdx),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqSuper   (reqSuper),
    .reqSpec    (reqSpec),
    .reqCancel  (reqCancel),
    .relocEn    (relocEn),
    .lk         (lk),
    .rspAccept  (rspAccept),
    .rspRetry   (rspRetry),
    .rspExcept  (rspExcept),
    .rspGuarded (rspGuarded)
  );

  dpu_datapath #(
    .NREG      (NREG),
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W),
    .CAL_BASE  (CAL_BASE),
    .CAL_MASK  (CAL_MASK),
    .LBUS_BASE (LBUS_BASE),
    .LBUS_MASK (LBUS_MASK)
  ) uData (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .wrIdx      (wrIdx),
    .cfgWrData  (cfgWrData),
    .cfgAddr    (cfgAddr),
    .cfgRdData  (cfgRdData),
    .reqAddr    (reqAddr),
    .reqCoreReg (reqCoreReg),
    .lk         (lk)
  );

endmodule

// File: tb/dpu_top_test.sv
module dpu_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0, reqSuper = 1'b0, reqSpec = 1'b0;
  logic        reqCoreReg = 1'b0, reqCancel = 1'b0, relocEn = 1'b1;
  logic        rspAccept, rspRetry, rspExcept, rspGuarded;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;

  // bench-side copy of the register map
  logic [31:0] sBase [4];
  logic [31:0] sMask [4];
  logic [3:0]  sAttr [4];
  logic [3:0]  sGlob;

  always #10 clk = ~clk;

  dpu_top uut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqSuper(reqSuper),
    .reqSpec(reqSpec), .reqCoreReg(reqCoreReg), .reqCancel(reqCancel),
    .relocEn(relocEn), .rspAccept(rspAccept), .rspRetry(rspRetry),
    .rspExcept(rspExcept), .rspGuarded(rspGuarded)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic grants(input logic [1:0] p, input logic s, input logic w);
    return (p == 2'b11) || (s && p != 2'b00) || (!s && p == 2'b10 && !w);
  endfunction

  // expected {accept, retry, except, guarded}
  function automatic logic [3:0] model(input logic [31:0] a, input logic w, input logic s,
                                       input logic sp, input logic co, input logic rl,
                                       input logic cn);
    logic [1:0] p;
    logic       g;
    if (cn) return 4'b0000;
    if (a[31:20] == 12'h003 || a[31:23] == 9'h001 || co) return 4'b1000;
    if (!rl) return sp ? 4'b0100 : 4'b1001;
    p = sGlob[2:1];
    g = sGlob[3];
    for (int i = 3; i >= 0; i--)
      if (sAttr[i][0] && ((a ^ sBase[i]) & sMask[i]) == 32'h0) begin
        p = sAttr[i][2:1];
        g = sAttr[i][3];
      end
    if (g && sp) return 4'b0100;
    if (grants(p, s, w)) return {3'b100, g};
    return 4'b0010;
  endfunction

  function automatic logic [31:0] expRead(input logic [3:0] a);
    case (a[3:2])
      2'd0: return sBase[a[1:0]];
      2'd1: return sMask[a[1:0]];
      2'd2: return {28'h0, sAttr[a[1:0]]};
      default: return (a[1:0] == 2'd0) ? {28'h0, sGlob} : 32'h0;
    endcase
  endfunction

  task automatic cfgWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    case (a[3:2])
      2'd0: sBase[a[1:0]] = d;
      2'd1: sMask[a[1:0]] = d;
      2'd2: sAttr[a[1:0]] = d[3:0];
      default: if (a[1:0] == 2'd0) sGlob = {d[3:1], 1'b0};
    endcase
  endtask

  task automatic cfgCheck(input logic [3:0] a, input string tag);
    cfgAddr = a;
    #1;
    check(tag, cfgRdData, expRead(a));
  endtask

  task automatic region(input int i, input logic [31:0] b, input logic [31:0] m,
                        input logic [3:0] at);
    cfgWrite(4'(i), b);
    cfgWrite(4'(4 + i), m);
    cfgWrite(4'(8 + i), {28'h0, at});
  endtask

  task automatic access(input logic [31:0] a, input logic w, input logic s, input logic sp,
                        input logic co, input logic rl, input logic cn, input string tag);
    logic [3:0] exp;
    @(negedge clk);
    // the cycle after a gap carries no response
    check("R1 idle", {28'h0, rspAccept, rspRetry, rspExcept, rspGuarded}, 32'h0);
    reqValid = 1'b1; reqAddr = a; reqWrite = w; reqSuper = s; reqSpec = sp;
    reqCoreReg = co; relocEn = rl; reqCancel = cn;
    exp = model(a, w, s, sp, co, rl, cn);
    @(negedge clk);
    reqValid = 1'b0; reqCancel = 1'b0;
    check(tag, {28'h0, rspAccept, rspRetry, rspExcept, rspGuarded}, {28'h0, exp});
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      sBase[i] = '0; sMask[i] = '0; sAttr[i] = '0;
    end
    sGlob = 4'h6;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset values and read map
    for (int a = 0; a < 16; a++) cfgCheck(4'(a), "R9 reset read");

    // R3: default global allows everything
    access(32'h4123_4560, 1, 0, 0, 0, 1, 0, "R3 global default");
    cfgWrite(4'hC, 32'h0000_0001);
    access(32'h4123_4560, 0, 0, 0, 0, 1, 0, "R3 R5 global no access");
    cfgWrite(4'hC, 32'h0000_000C);  // guarded, user read
    cfgCheck(4'hC, "R9 global enable bit reads 0");
    access(32'h4123_4560, 0, 0, 1, 0, 1, 0, "R3 R6 global guarded spec");
    access(32'h4123_4560, 0, 0, 0, 0, 1, 0, "R3 R6 global guarded accept");
    cfgWrite(4'hD, 32'hFFFF_FFFF);
    cfgCheck(4'hD, "R9 unused slot");
    cfgWrite(4'hC, 32'h0000_0006);

    // R2: overlap priority
    region(0, 32'h4000_0000, 32'hFFFF_0000, 4'b0001);  // no access
    region(1, 32'h4000_0000, 32'hFF00_0000, 4'b0111);  // full
    region(2, 32'h4000_0000, 32'hF000_0000, 4'b1110);  // disabled, guarded
    access(32'h4000_1234, 0, 1, 0, 0, 1, 0, "R2 lowest index wins");
    access(32'h4001_0000, 1, 0, 0, 0, 1, 0, "R2 second region");
    access(32'h4400_0000, 1, 0, 1, 0, 1, 0, "R2 disabled region ignored");

    // R4: protection code matrix through region 0
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 2; s++)
        for (int w = 0; w < 2; w++) begin
          cfgWrite(4'h8, {28'h0, 1'b0, 2'(p), 1'b1});
          access(32'h4000_0010, w[0], s[0], 0, 0, 1, 0, "R4 protection code");
        end

    // R5 / R6: guarded handling
    cfgWrite(4'h8, {28'h0, 4'b1001});  // guarded, no access
    access(32'h4000_0010, 0, 1, 1, 0, 1, 0, "R6 guarded spec violation retried");
    access(32'h4000_0010, 0, 1, 0, 0, 1, 0, "R5 guarded violation faults when non-spec");
    cfgWrite(4'h8, {28'h0, 4'b1111});
    access(32'h4000_0010, 1, 0, 0, 0, 1, 0, "R6 guarded accept flag");
    cfgWrite(4'h8, {28'h0, 4'b0001});
    access(32'h4000_0010, 0, 0, 1, 0, 1, 0, "R5 unguarded spec violation faults");

    // R7: relocation off
    access(32'h4000_0010, 1, 0, 1, 0, 0, 0, "R7 spec retried");
    access(32'h4000_0010, 1, 0, 0, 0, 0, 0, "R7 no fault, guarded");

    // R8: exclusion windows and core-register flag
    region(3, 32'h0000_0000, 32'hF000_0000, 4'b1001);
    access(32'h0031_0000, 1, 0, 1, 0, 1, 0, "R8 calibration window");
    access(32'h0090_0000, 1, 0, 0, 0, 1, 0, "R8 local bus window");
    access(32'h0500_0000, 1, 0, 0, 0, 1, 0, "R8 outside windows faults");
    access(32'h0500_0000, 1, 0, 1, 1, 1, 0, "R8 core register flag");
    access(32'h0031_0000, 0, 0, 1, 0, 0, 0, "R8 window with relocation off");

    // R10: cancel
    access(32'h0500_0000, 1, 0, 0, 0, 1, 1, "R10 cancelled violation");
    access(32'h4000_0010, 1, 0, 1, 0, 0, 1, "R10 cancelled retry");

    // random phase
    for (int it = 0; it < 600; it++) begin
      logic [31:0] a;
      int r;
      if (it % 60 == 0) begin
        for (int i = 0; i < 4; i++) begin
          int k;
          logic [31:0] m;
          k = 8 + int'($urandom % 16);
          m = 32'hFFFF_FFFF << k;
          region(i, {4'h4, 28'($urandom)} & m, m, 4'($urandom));
        end
        cfgWrite(4'hC, $urandom);
        for (int c = 0; c < 13; c++) cfgCheck(4'(c), "R9 random readback");
      end
      r = int'($urandom % 8);
      if (r < 4)       a = sBase[r] | ($urandom & ~sMask[r]);
      else if (r == 4) a = 32'h0030_0000 | ($urandom & 32'h000F_FFFF);
      else             a = {4'h4, 28'($urandom)};
      access(a, 1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 10) == 0,
             ($urandom % 8) != 0, ($urandom % 16) == 0, "R2 R4 R6 R7 R8 R10 random");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule